// File: doc/BRIEF.md
# Three-Source Memory Access Arbiter

This block sits in front of a single memory controller and decides which of three clients may use it: instruction-cache miss reads, data-cache miss reads, and drains from a store buffer. Each client raises a request with an address (the store buffer also supplies write data). The arbiter grants exactly one client, routes that client's request onto the controller port, and keeps the grant until the controller reports completion. Completion is passed back to the granted client as a one-cycle done pulse.

The ranking depends on state. A store buffer that reports itself full goes first. Otherwise pending read misses go before the store buffer. When both caches miss at the same time, they take turns. A non-full store buffer drains only in idle moments when no read miss is pending. A grant is never taken away partway through an access. A client that has just been served must drop its request for at least one cycle before it can win again.

Top module: `mem_arb3`

## Requirements
- R1: While reset is active (rst_n low), all three grants, all done pulses and ctl_req are 0.
- R2: At most one of ic_gnt, dc_gnt, wb_gnt is high in any cycle.
- R3: When the arbiter is idle and the store buffer is eligible with wb_full high, the next cycle grants the store buffer, whatever else is requesting.
- R4: When the arbiter is idle, at least one cache is eligible, and a full store buffer is not eligible, the next grant goes to a cache and not to the store buffer.
- R5: When both caches are eligible in an idle cycle, the grant goes to the cache not served by the most recent cache grant. The instruction cache wins the first such tie after reset.
- R6: A non-full store buffer is granted only in a cycle that follows an idle cycle with no cache eligible.
- R7: While a grant is active and ctl_done is low, the grant vector does not change.
- R8: In a cycle with an active grant, the granted client's done output equals ctl_done and every other done output is 0. In the cycle after ctl_done, all grants are 0.
- R9: After a client's done pulse, that client is not eligible again until its request has been sampled low on at least one clock edge. A request held continuously high through and after done is ignored.
- R10: ctl_req is high exactly when a grant is active. ctl_we is high only for a store-buffer grant. ctl_addr carries the granted client's address, or 0 when idle. ctl_wdata carries wb_wdata during a store-buffer grant, and 0 otherwise.
- R11: An idle cycle with any eligible client is followed by a cycle with a grant. A client is eligible when its request is high and it has re-armed (see R9).
- R12: A store-buffer grant does not change the turn-taking record between the two caches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ic_req | input | 1 | Instruction-cache miss read request |
| ic_addr | input | ADDR_W | Instruction-cache miss word address |
| ic_gnt | output | 1 | Instruction cache owns the controller |
| ic_done | output | 1 | Instruction-cache access complete |
| dc_req | input | 1 | Data-cache miss read request |
| dc_addr | input | ADDR_W | Data-cache miss word address |
| dc_gnt | output | 1 | Data cache owns the controller |
| dc_done | output | 1 | Data-cache access complete |
| wb_req | input | 1 | Store-buffer drain request |
| wb_full | input | 1 | Store buffer has no free entry |
| wb_addr | input | ADDR_W | Drain word address |
| wb_wdata | input | DATA_W | Drain write data |
| wb_gnt | output | 1 | Store buffer owns the controller |
| wb_done | output | 1 | Drain write complete |
| ctl_req | output | 1 | Access request to the controller |
| ctl_we | output | 1 | Access is a write |
| ctl_addr | output | ADDR_W | Access word address |
| ctl_wdata | output | DATA_W | Access write data |
| ctl_done | input | 1 | Controller finished the current access |

## Verification
The hardest situations to reach are a cache that keeps its request high straight through its own done pulse, and a full store buffer that jumps between two caches taking turns. In both, the correct winner depends on history that is not visible at the ports. The stimulus therefore runs in phases. In one phase, the clients often hold their requests high after done. In another, both caches miss nearly every cycle while wb_full switches on and off at random. A behavioural model in the bench keeps its own turn record and re-arm bits and is compared with the outputs every cycle.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned SRC_IC  = 0;
  localparam int unsigned SRC_DC  = 1;
  localparam int unsigned SRC_WB  = 2;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

  // State-dependent ranking: full store buffer, then reads (alternating), then drain.
  function automatic src_vec_t arb_choose(input src_vec_t elig,
                                          input logic     wb_full,
                                          input logic     dc_was_last);
    src_vec_t win;
    win = '0;
    if (elig[SRC_WB] && wb_full) begin
      win[SRC_WB] = 1'b1;
    end else if (elig[SRC_IC] && elig[SRC_DC]) begin
      if (dc_was_last) win[SRC_IC] = 1'b1;
      else             win[SRC_DC] = 1'b1;
    end else if (elig[SRC_IC]) begin
      win[SRC_IC] = 1'b1;
    end else if (elig[SRC_DC]) begin
      win[SRC_DC] = 1'b1;
    end else if (elig[SRC_WB]) begin
      win[SRC_WB] = 1'b1;
    end
    return win;
  endfunction

  function automatic logic is_read_src(input src_vec_t g);
    return g[SRC_IC] | g[SRC_DC];
  endfunction
endpackage

// File: rtl/arb_rearm.sv
module arb_rearm #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] done,
  output logic [N-1:0] armed
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed[i] <= 1'b1;
      else if (!req[i]) armed[i] <= 1'b1;
      else if (done[i]) armed[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import mem_arb_pkg::*;
(
  input  src_vec_t elig,
  input  logic     wb_full,
  input  logic     dc_was_last,
  output src_vec_t choice
);
  always_comb choice = arb_choose(elig, wb_full, dc_was_last);
endmodule

// File: rtl/arb_hold.sv
module arb_hold
  import mem_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t choice,
  input  logic     ctl_done,
  output src_vec_t gnt,
  output logic     dc_was_last
);
  arb_state_e state_q;
  src_vec_t   gnt_q;
  logic       dc_last_q;
  logic       launch;

  assign launch = (state_q == ARB_IDLE) && (choice != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ARB_IDLE;
      gnt_q     <= '0;
      dc_last_q <= 1'b1;
    end else begin
      case (state_q)
        ARB_IDLE: if (launch) begin
          state_q <= ARB_BUSY;
          gnt_q   <= choice;
          if (is_read_src(choice)) dc_last_q <= choice[SRC_DC];
        end
        ARB_BUSY: if (ctl_done) begin
          state_q <= ARB_IDLE;
          gnt_q   <= '0;
        end
        default: begin
          state_q <= ARB_IDLE;
          gnt_q   <= '0;
        end
      endcase
    end
  end

  assign gnt         = gnt_q;
  assign dc_was_last = dc_last_q;
endmodule

// File: rtl/arb_route.sv
module arb_route
  import mem_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned DATA_W = 32
) (
  input  src_vec_t          gnt,
  input  logic              ctl_done,
  input  logic [ADDR_W-1:0] ic_addr,
  input  logic [ADDR_W-1:0] dc_addr,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_wdata,
  output logic              ctl_req,
  output logic              ctl_we,
  output logic [ADDR_W-1:0] ctl_addr,
  output logic [DATA_W-1:0] ctl_wdata,
  output src_vec_t          done_vec
);
  logic [ADDR_W-1:0] addr_tab [NUM_SRC];

  always_comb begin
    addr_tab[SRC_IC] = ic_addr;
    addr_tab[SRC_DC] = dc_addr;
    addr_tab[SRC_WB] = wb_addr;
  end

  always_comb begin
    ctl_addr = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      ctl_addr = ctl_addr | (addr_tab[i] & {ADDR_W{gnt[i]}});
    end
  end

  assign ctl_req   = |gnt;
  assign ctl_we    = gnt[SRC_WB];
  assign ctl_wdata = wb_wdata & {DATA_W{gnt[SRC_WB]}};
  assign done_vec  = gnt & {NUM_SRC{ctl_done}};
endmodule

// File: rtl/mem_arb3.sv
module mem_arb3
  import mem_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ic_req,
  input  logic [ADDR_W-1:0] ic_addr,
  output logic              ic_gnt,
  output logic              ic_done,
  input  logic              dc_req,
  input  logic [ADDR_W-1:0] dc_addr,
  output logic              dc_gnt,
  output logic              dc_done,
  input  logic              wb_req,
  input  logic              wb_full,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_wdata,
  output logic              wb_gnt,
  output logic              wb_done,
  output logic              ctl_req,
  output logic              ctl_we,
  output logic [ADDR_W-1:0] ctl_addr,
  output logic [DATA_W-1:0] ctl_wdata,
  input  logic              ctl_done
);
  // Named internal events, also observed by the bound checker
  src_vec_t req_vec;
  src_vec_t armed;
  src_vec_t elig;
  src_vec_t choice;
  src_vec_t gnt_vec;
  src_vec_t done_vec;
  logic     dc_was_last;

  always_comb begin
    req_vec         = '0;
    req_vec[SRC_IC] = ic_req;
    req_vec[SRC_DC] = dc_req;
    req_vec[SRC_WB] = wb_req;
  end

  assign elig = req_vec & armed;

  arb_rearm #(.N(NUM_SRC)) u_rearm (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_vec),
    .done  (done_vec),
    .armed (armed)
  );

  arb_pick u_pick (
    .elig        (elig),
    .wb_full     (wb_full),
    .dc_was_last (dc_was_last),
    .choice      (choice)
  );

  arb_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .choice      (choice),
    .ctl_done    (ctl_done),
    .gnt         (gnt_vec),
    .dc_was_last (dc_was_last)
  );

  arb_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .gnt       (gnt_vec),
    .ctl_done  (ctl_done),
    .ic_addr   (ic_addr),
    .dc_addr   (dc_addr),
    .wb_addr   (wb_addr),
    .wb_wdata  (wb_wdata),
    .ctl_req   (ctl_req),
    .ctl_we    (ctl_we),
    .ctl_addr  (ctl_addr),
    .ctl_wdata (ctl_wdata),
    .done_vec  (done_vec)
  );

  assign ic_gnt  = gnt_vec[SRC_IC];
  assign dc_gnt  = gnt_vec[SRC_DC];
  assign wb_gnt  = gnt_vec[SRC_WB];
  assign ic_done = done_vec[SRC_IC];
  assign dc_done = done_vec[SRC_DC];
  assign wb_done = done_vec[SRC_WB];
endmodule

// File: rtl/mem_arb3_chk.sv
module mem_arb3_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        gnt,
  input logic [2:0]        elig,
  input logic              ic_req,
  input logic              wb_full,
  input logic              ctl_done,
  input logic              ctl_we,
  input logic [DATA_W-1:0] ctl_wdata,
  input logic [DATA_W-1:0] wb_wdata
);
  assert_single_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_full_buffer_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 3'b000 && elig[2] && wb_full) |=> gnt[2]);

  assert_reads_before_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 3'b000 && (elig[0] || elig[1]) && !(elig[2] && wb_full)) |=> (gnt[0] || gnt[1]));

  assert_hold_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 3'b000 && !ctl_done) |=> $stable(gnt));

  assert_release_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 3'b000 && ctl_done) |=> gnt == 3'b000);

  assert_rerequest_needed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[0] && ctl_done && ic_req) ##1 ic_req |=> !gnt[0]);

  assert_write_routing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[2] |-> (ctl_we && ctl_wdata == wb_wdata));

  assert_idle_grants_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 3'b000 && elig != 3'b000) |=> gnt != 3'b000);
endmodule

bind mem_arb3 mem_arb3_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gnt       (gnt_vec),
  .elig      (elig),
  .ic_req    (ic_req),
  .wb_full   (wb_full),
  .ctl_done  (ctl_done),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .wb_wdata  (wb_wdata)
);

// File: tb/tb_mem_arb3.sv
module tb_mem_arb3;
  localparam int AW = 23;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          ic_req = 0, dc_req = 0, wb_req = 0, wb_full = 0, ctl_done = 0;
  logic [AW-1:0] ic_addr = '0, dc_addr = '0, wb_addr = '0;
  logic [DW-1:0] wb_wdata = '0;
  logic          ic_gnt, dc_gnt, wb_gnt, ic_done, dc_done, wb_done;
  logic          ctl_req, ctl_we;
  logic [AW-1:0] ctl_addr;
  logic [DW-1:0] ctl_wdata;

  mem_arb3 #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ic_req(ic_req), .ic_addr(ic_addr), .ic_gnt(ic_gnt), .ic_done(ic_done),
    .dc_req(dc_req), .dc_addr(dc_addr), .dc_gnt(dc_gnt), .dc_done(dc_done),
    .wb_req(wb_req), .wb_full(wb_full), .wb_addr(wb_addr), .wb_wdata(wb_wdata),
    .wb_gnt(wb_gnt), .wb_done(wb_done),
    .ctl_req(ctl_req), .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .ctl_done(ctl_done)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Behavioural reference: owner index (-1 idle), whose turn, re-arm flags
  int    m_owner = -1;
  int    m_last_read = 1;     // 0: instruction cache served last, 1: data cache
  bit    m_armed [3] = '{1, 1, 1};
  bit    m_wb_since_read = 0;
  string m_why = "R1";

  always @(posedge clk) begin
    bit r [3];
    bit d [3];
    bit e [3];
    int sel;
    r = '{ic_req, dc_req, wb_req};
    if (!rst_n) begin
      m_owner = -1; m_last_read = 1; m_armed = '{1, 1, 1};
      m_wb_since_read = 0; m_why = "R1";
    end else begin
      for (int i = 0; i < 3; i++) d[i] = (m_owner == i) && ctl_done;
      if (m_owner >= 0) begin
        m_why = "R7";
        if (ctl_done) begin m_owner = -1; m_why = "R8"; end
      end else begin
        for (int i = 0; i < 3; i++) e[i] = r[i] && m_armed[i];
        sel = -1;
        if (e[2] && wb_full) begin sel = 2; m_why = "R3"; end
        else if (e[0] && e[1]) begin
          sel = (m_last_read == 1) ? 0 : 1;
          m_why = m_wb_since_read ? "R12" : "R5";
        end
        else if (e[0] || e[1]) begin sel = e[0] ? 0 : 1; m_why = e[2] ? "R4" : "R11"; end
        else if (e[2]) begin sel = 2; m_why = "R6"; end
        else m_why = "R11";
        for (int i = 0; i < 3; i++) if (r[i] && !m_armed[i]) m_why = "R9";
        if (sel >= 0) begin
          m_owner = sel;
          if (sel < 2) begin m_last_read = sel; m_wb_since_read = 0; end
          else m_wb_since_read = 1;
        end
      end
      for (int i = 0; i < 3; i++) begin
        if (!r[i]) m_armed[i] = 1;
        else if (d[i]) m_armed[i] = 0;
      end
    end
  end

  task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
  endtask

  bit seen_done [3] = '{0, 0, 0};

  always @(negedge clk) begin
    logic [2:0]    eg, ed, ag, ad;
    logic [AW-1:0] ea;
    logic [DW-1:0] ew;
    ag = {wb_gnt, dc_gnt, ic_gnt};
    ad = {wb_done, dc_done, ic_done};
    seen_done = '{ic_done, dc_done, wb_done};
    n_vec++;
    if (!rst_n) begin
      if (ag != 3'b000 || ad != 3'b000 || ctl_req) fail_line("R1", "reset outputs", {ag, ad, ctl_req}, 0);
    end else begin
      eg = 3'b000; ea = '0; ew = '0;
      if (m_owner >= 0) eg[m_owner] = 1'b1;
      ed = eg & {3{ctl_done}};
      if (m_owner == 0) ea = ic_addr;
      if (m_owner == 1) ea = dc_addr;
      if (m_owner == 2) begin ea = wb_addr; ew = wb_wdata; end
      if ($countones(ag) > 1) fail_line("R2", "multiple grants", ag, eg);
      if (ag != eg) fail_line(m_why, "grant vector", ag, eg);
      if (ad != ed) fail_line("R8", "done vector", ad, ed);
      if (ctl_req != (m_owner >= 0)) fail_line("R10", "ctl_req", ctl_req, m_owner >= 0);
      if (ctl_we != (m_owner == 2)) fail_line("R10", "ctl_we", ctl_we, m_owner == 2);
      if (ctl_addr != ea) fail_line("R10", "ctl_addr", ctl_addr, ea);
      if (ctl_wdata != ew) fail_line("R10", "ctl_wdata", ctl_wdata, ew);
    end
  end

  // Phase knobs
  int  p_raise = 50;
  int  p_full  = 0;
  int  p_stick = 0;
  bit  en [3]  = '{1, 1, 1};

  task automatic run_cycles(int n);
    for (int c = 0; c < n; c++) begin
      bit rq [3];
      @(posedge clk);
      #1;
      rq = '{ic_req, dc_req, wb_req};
      for (int i = 0; i < 3; i++) begin
        if (!en[i]) rq[i] = 0;
        else if (rq[i] && seen_done[i]) begin
          if (($urandom % 100) >= p_stick) rq[i] = 0;
        end else if (!rq[i] && ($urandom % 100) < p_raise) begin
          rq[i] = 1;
          if (i == 0) ic_addr = AW'($urandom);
          if (i == 1) dc_addr = AW'($urandom);
          if (i == 2) begin wb_addr = AW'($urandom); wb_wdata = DW'($urandom); end
        end
      end
      ic_req = rq[0]; dc_req = rq[1]; wb_req = rq[2];
      wb_full  = en[2] && (($urandom % 100) < p_full);
      ctl_done = ctl_req && (($urandom % 4) == 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R5: all three at once, non-full buffer: instruction cache wins first tie
    ic_req = 1; dc_req = 1; wb_req = 1; ic_addr = 23'h1234; dc_addr = 23'h0abc; wb_addr = 23'h7777;
    wb_wdata = 32'hcafe0001;
    run_cycles(40);
    // R3 and R12: full buffer mixed with two busy caches
    p_raise = 70; p_full = 40; run_cycles(800);
    // R9: caches hold requests through done; R5 alternation under pressure
    en = '{1, 1, 0}; p_raise = 90; p_stick = 70; p_full = 0; run_cycles(800);
    // R6: drain alone, never full
    en = '{0, 0, 1}; p_stick = 0; p_raise = 60; run_cycles(400);
    // R4 and R11: mixed traffic with occasional full buffer
    en = '{1, 1, 1}; p_raise = 35; p_full = 15; run_cycles(1000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog expired: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule